// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Controller

This block drives the enable pin of an external regulator. A second alarm of the real-time clock can switch the system off through it, and external wake pins can switch it back on. The clock counter and its compare logic sit outside the block. They deliver a one-cycle alarm-match pulse in the 32 kHz domain. Each match latches an event flag that software clears by writing a one, and the flag can raise an interrupt. When software has handed control of the pin to the block, the same match drives the power-enable output low.

While power is off, each wake pin is brought into the 32 kHz domain by a two-flop synchroniser. It is then qualified by its own enable bit and its own polarity bit. Any qualified pin returns the output high. A small register window holds three words: status, interrupt enable and power control. It has byte strobes and a combinational read.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset, pwr_en is 1, alarm_irq is 0, and the words at offsets 0x00, 0x04 and 0x08 all read 0.
- R2: An alarm_match pulse sets the event flag at bit 7 of offset 0x00. A write to 0x00 with bit 7 set and byte strobe 0 active clears the flag. A write with bit 7 clear leaves it unchanged.
- R3: An alarm_match pulse in the same cycle as a clearing write leaves the event flag set.
- R4: Offset 0x04 bit 4 enables the interrupt, and alarm_irq is high exactly while both the flag and this bit are 1. The word at 0x04 changes only when all four byte strobes are active.
- R5: When power-control bit 16 (offset 0x08) is 1, an alarm_match pulse sampled at a clock edge makes pwr_en 0 from that edge on. When the bit is 0, pwr_en stays 1 and the flag is still set.
- R6: While pwr_en is 0, wake pin i returns pwr_en to 1 on the third clock edge after the pin reaches its active level, if its enable bit i at 0x08 is 1. Polarity bit 4+i selects the active level: 0 means active high, 1 means active low.
- R7: A wake pin whose enable bit is 0, or a pin at its inactive level, leaves pwr_en at 0.
- R8: A further alarm_match while pwr_en is 0 and no wake pin qualifies keeps pwr_en at 0.
- R9: Writes to offset 0x08 update only the bytes whose strobe is active. Only bits 0..7 and 16 are stored; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte strobes for the write |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| alarm_match | input | 1 | One-cycle second-alarm match pulse |
| wake_in | input | 4 | Asynchronous external wake pins |
| pwr_en | output | 1 | Regulator enable, 1 = on |
| alarm_irq | output | 1 | Second-alarm interrupt request |

## Verification
Two functions can land on the same clock edge: the alarm match setting the event flag, and a software write clearing that flag. The bench raises alarm_match at the same falling edge where it presents a write of 0x80 to the status word, so both reach the register on one rising edge. It then reads the status word back and expects bit 7 to still be set. A bound property checks the same outcome on every cycle in which both occur.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic {
    PS_ON  = 1'b0,
    PS_OFF = 1'b1
  } pwr_state_t;

  // Merge a 32-bit write into a stored word, one byte lane per strobe.
  function automatic logic [31:0] lane_merge(
    input logic [31:0] old_w,
    input logic [31:0] new_w,
    input logic [3:0]  be
  );
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
    end
    return r;
  endfunction

  // True only for a full-word write.
  function automatic logic full_word(input logic [3:0] be);
    return &be;
  endfunction

  // A wake pin is asserted when its level differs from the polarity bit.
  function automatic logic pin_active(input logic lvl, input logic act_low);
    return lvl ^ act_low;
  endfunction

endpackage

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
  import pwrseq_pkg::*;
#(
  parameter int NWAKE    = 4,
  parameter int ADDR_W   = 8,
  parameter int OFS_STS  = 'h00,
  parameter int OFS_IE   = 'h04,
  parameter int OFS_CTL  = 'h08,
  parameter int FLAG_BIT = 7,
  parameter int IE_BIT   = 4,
  parameter int CTL_BIT  = 16,
  parameter int POL_LSB  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  output logic [31:0]       rdata,
  input  logic              alarm_evt,
  output logic              sts_clr,
  output logic              alarm_flag,
  output logic              alarm_ie,
  output logic              ctl_en,
  output logic [NWAKE-1:0]  wake_en,
  output logic [NWAKE-1:0]  wake_pol
);

  localparam logic [31:0] EN_MASK  = (32'd1 << NWAKE) - 32'd1;
  localparam logic [31:0] CTL_MASK = (32'd1 << CTL_BIT) | EN_MASK | (EN_MASK << POL_LSB);

  logic        hit_sts, hit_ie, hit_ctl;
  logic [31:0] ctl_q;

  assign hit_sts = wr && (addr == ADDR_W'(OFS_STS));
  assign hit_ie  = wr && (addr == ADDR_W'(OFS_IE));
  assign hit_ctl = wr && (addr == ADDR_W'(OFS_CTL));

  assign sts_clr = hit_sts && be[FLAG_BIT/8] && wdata[FLAG_BIT];

  // Event flag: a new match has priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_flag <= 1'b0;
    end else if (alarm_evt) begin
      alarm_flag <= 1'b1;
    end else if (sts_clr) begin
      alarm_flag <= 1'b0;
    end
  end

  // Interrupt enable takes only full-word writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_ie <= 1'b0;
    end else if (hit_ie && full_word(be)) begin
      alarm_ie <= wdata[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (hit_ctl) begin
      ctl_q <= lane_merge(ctl_q, wdata, be) & CTL_MASK;
    end
  end

  assign ctl_en   = ctl_q[CTL_BIT];
  assign wake_en  = ctl_q[NWAKE-1:0];
  assign wake_pol = ctl_q[POL_LSB +: NWAKE];

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_STS)) begin
      rdata[FLAG_BIT] = alarm_flag;
    end else if (addr == ADDR_W'(OFS_IE)) begin
      rdata[IE_BIT] = alarm_ie;
    end else if (addr == ADDR_W'(OFS_CTL)) begin
      rdata = ctl_q;
    end
  end

endmodule

// File: rtl/pwrseq_wake.sv
module pwrseq_wake
  import pwrseq_pkg::*;
#(
  parameter int NWAKE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NWAKE-1:0] pin,
  input  logic [NWAKE-1:0] en,
  input  logic [NWAKE-1:0] act_low,
  output logic [NWAKE-1:0] hit,
  output logic             any_hit
);

  logic [NWAKE-1:0] s1_q, s2_q;

  for (genvar i = 0; i < NWAKE; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= pin[i];
        s2_q[i] <= s1_q[i];
      end
    end
    assign hit[i] = en[i] && pin_active(s2_q[i], act_low[i]);
  end

  assign any_hit = |hit;

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_en,
  input  logic alarm_evt,
  input  logic wake_any,
  output logic off_evt,
  output logic on_evt,
  output logic pwr_en
);

  pwr_state_t st_q, st_d;

  assign off_evt = (st_q == PS_ON) && ctl_en && alarm_evt;
  assign on_evt  = (st_q == PS_OFF) && wake_any;

  always_comb begin
    st_d = st_q;
    if (off_evt) begin
      st_d = PS_OFF;
    end else if (on_evt) begin
      st_d = PS_ON;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_ON;
    end else begin
      st_q <= st_d;
    end
  end

  assign pwr_en = (st_q == PS_ON);

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int NWAKE  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_be,
  output logic [31:0]       reg_rdata,
  input  logic              alarm_match,
  input  logic [NWAKE-1:0]  wake_in,
  output logic              pwr_en,
  output logic              alarm_irq
);

  logic             sts_clr, alarm_flag, alarm_ie, ctl_en;
  logic [NWAKE-1:0] wake_en, wake_pol, wake_hit;
  logic             wake_any, off_evt, on_evt;

  pwrseq_regs #(.NWAKE(NWAKE), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .be(reg_be), .rdata(reg_rdata),
    .alarm_evt(alarm_match), .sts_clr(sts_clr), .alarm_flag(alarm_flag),
    .alarm_ie(alarm_ie), .ctl_en(ctl_en), .wake_en(wake_en), .wake_pol(wake_pol)
  );

  pwrseq_wake #(.NWAKE(NWAKE)) u_wake (
    .clk(clk), .rst_n(rst_n), .pin(wake_in), .en(wake_en),
    .act_low(wake_pol), .hit(wake_hit), .any_hit(wake_any)
  );

  pwrseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .alarm_evt(alarm_match),
    .wake_any(wake_any), .off_evt(off_evt), .on_evt(on_evt), .pwr_en(pwr_en)
  );

  assign alarm_irq = alarm_flag && alarm_ie;

endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic alarm_match,
  input logic sts_clr,
  input logic ctl_en,
  input logic wake_any,
  input logic alarm_flag,
  input logic alarm_ie,
  input logic alarm_irq,
  input logic pwr_en
);

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_match |=> alarm_flag);

  assert_set_beats_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_match && sts_clr) |=> alarm_flag);

  assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_ie |-> !alarm_irq);

  assert_alarm_powers_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && ctl_en && alarm_match) |=> !pwr_en);

  assert_stay_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !(ctl_en && alarm_match)) |=> pwr_en);

  assert_wake_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && wake_any) |=> pwr_en);

  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && !wake_any) |=> !pwr_en);

endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alarm_match(alarm_match), .sts_clr(sts_clr),
  .ctl_en(ctl_en), .wake_any(wake_any), .alarm_flag(alarm_flag),
  .alarm_ie(alarm_ie), .alarm_irq(alarm_irq), .pwr_en(pwr_en)
);

// File: tb/pwrseq_ctrl_bench.sv
module pwrseq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_rdata;
  logic        alarm_match = 1'b0;
  logic [3:0]  wake_in = '0;
  logic        pwr_en, alarm_irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwrseq_ctrl u_pwrseq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .alarm_match(alarm_match), .wake_in(wake_in), .pwr_en(pwr_en),
    .alarm_irq(alarm_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_alarm();
    @(negedge clk);
    alarm_match = 1'b1;
    @(negedge clk);
    alarm_match = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pwr_en", {31'b0, pwr_en}, 32'd1);
    chk("R1 irq", {31'b0, alarm_irq}, 32'd0);
    rd(8'h00, d); chk("R1 status", d, 32'h0);
    rd(8'h04, d); chk("R1 ie", d, 32'h0);
    rd(8'h08, d); chk("R1 ctl", d, 32'h0);
  endtask

  task automatic t_flag();
    logic [31:0] d;
    pulse_alarm();
    rd(8'h00, d); chk("R2 set", d, 32'h80);
    chk("R5 no ctl keeps on", {31'b0, pwr_en}, 32'd1);
    wr(8'h00, 32'h0000_007F, 4'hF);
    rd(8'h00, d); chk("R2 zero write", d, 32'h80);
    wr(8'h00, 32'h0000_0080, 4'hF);
    rd(8'h00, d); chk("R2 clear", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk);
    alarm_match = 1'b1;
    reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h80; reg_be = 4'hF;
    @(negedge clk);
    alarm_match = 1'b0; reg_wr = 1'b0; reg_be = '0;
    rd(8'h00, d); chk("R3 set wins", d, 32'h80);
    wr(8'h00, 32'h80, 4'h1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h04, 32'h10, 4'h1);
    rd(8'h04, d); chk("R4 partial ignored", d, 32'h0);
    wr(8'h04, 32'h10, 4'hF);
    rd(8'h04, d); chk("R4 full write", d, 32'h10);
    pulse_alarm();
    chk("R4 irq high", {31'b0, alarm_irq}, 32'd1);
    wr(8'h00, 32'h80, 4'h1);
    chk("R4 irq low", {31'b0, alarm_irq}, 32'd0);
  endtask

  task automatic t_bytes();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF, 4'b0100);
    rd(8'h08, d); chk("R9 lane2", d, 32'h0001_0000);
    wr(8'h08, 32'hFFFF_FFFF, 4'b0001);
    rd(8'h08, d); chk("R9 lane0", d, 32'h0001_00FF);
  endtask

  task automatic t_wake_high();
    wake_in = 4'b0000;
    wr(8'h08, 32'h0001_0001, 4'hF);
    idle(3);
    pulse_alarm();
    chk("R5 off", {31'b0, pwr_en}, 32'd0);
    wake_in = 4'b0010;
    idle(5);
    chk("R7 disabled pin", {31'b0, pwr_en}, 32'd0);
    @(negedge clk); wake_in = 4'b0011;
    idle(2);
    chk("R6 latency not yet", {31'b0, pwr_en}, 32'd0);
    idle(1);
    chk("R6 active high wakes", {31'b0, pwr_en}, 32'd1);
  endtask

  task automatic t_wake_low();
    wake_in = 4'b0100;
    wr(8'h08, 32'h0001_0044, 4'hF);
    idle(3);
    pulse_alarm();
    chk("R5 off again", {31'b0, pwr_en}, 32'd0);
    idle(4);
    chk("R7 inactive level", {31'b0, pwr_en}, 32'd0);
    pulse_alarm();
    chk("R8 alarm while off", {31'b0, pwr_en}, 32'd0);
    @(negedge clk); wake_in = 4'b0000;
    idle(2);
    chk("R6 low latency not yet", {31'b0, pwr_en}, 32'd0);
    idle(1);
    chk("R6 active low wakes", {31'b0, pwr_en}, 32'd1);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_flag();
    t_collide();
    t_irq();
    t_bytes();
    t_wake_high();
    t_wake_low();
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule